// File: doc/BRIEF.md
# Serializer Buffer Access Router

This block connects a simple host register bus to the data buffers of a row of audio serializers. Each serializer is set as idle, transmit or receive by a two-bit field. The host reaches the buffers in one of two ways, and the choice is made separately for the transmit and the receive direction. In shared-port mode a single address serves every buffer of that direction. Writes fill the transmit serializers and reads drain the receive serializers, always from the lowest active index upward, and idle indices are skipped. In direct mode each serializer has its own address, equal to a base address plus its index.

A slot strobe marks the boundary between time slots. At each boundary the block checks that every transmit buffer was filled and every receive buffer was drained. A missed transmit buffer raises a sticky underrun flag, and an undrained receive buffer raises a sticky overrun flag. The strobe then empties all buffers and applies any pending configuration. A capture strobe loads new receive data from the serializer side and raises a receive-ready event. A transmit-ready event follows every slot strobe.

Register map: address 0 is the shared port. Address 1 is the pending path select, where bit 0 = 1 selects direct mode for transmit and bit 1 = 1 selects direct mode for receive. Address 2 holds the pending mode word, with serializer n in bits [2n+1:2n]: 01 = transmit, 10 = receive, 00 or 11 = idle. Address 3 is status, written 1 to clear: bit 0 underrun, bit 1 overrun, bit 2 excess shared write, bit 3 excess shared read. Addresses CFG_BASE to CFG_BASE+NSER-1 are the direct buffers.

Top module: `sbuf_router`

## Requirements
- R1: After reset, bus_rdata, tx_full, underrun, overrun, tx_ready, rx_ready and the status register read as zero, and every serializer is idle and in shared-port mode.
- R2: Writes to the mode word (address 2) or the path select (address 1) take effect only at the next slot_tick. Before that tick, a shared-port write changes no tx_full bit.
- R3: In shared-port transmit mode, successive writes to address 0 fill the active transmit serializers in ascending index order and skip the others. Each write sets exactly one tx_full bit, and that lane of tx_out carries the written word.
- R4: In shared-port receive mode, successive reads from address 0 return the captured words of the active receive serializers in ascending index order, on bus_rdata one cycle after bus_rd.
- R5: A shared-port write made when every active transmit buffer is already full changes nothing and sets status bit 2. A shared-port read made when no receive buffer is pending returns 0 and sets status bit 3.
- R6: In direct transmit mode, a write to CFG_BASE+n fills buffer n if serializer n is set to transmit. While direct mode is selected, writes to address 0 have no effect.
- R7: In direct mode, a write or read at CFG_BASE+n has no effect when serializer n is idle or set to the opposite direction, and such a read returns 0. A read of a receive serializer returns its captured word.
- R8: At a slot_tick, if any active transmit serializer has tx_full clear, underrun is set in the next cycle. After every tick, tx_full is all zero.
- R9: At a slot_tick, if any active receive serializer still holds an unread word, overrun is set in the next cycle.
- R10: Status bits stay set until a write to address 3 with a 1 in that bit position. Bits written as 0 are kept.
- R11: tx_ready pulses for one cycle after each slot_tick. rx_ready pulses for one cycle after a rx_capture when at least one serializer is set to receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | AW | Host word address |
| bus_wdata | input | DW | Host write data |
| bus_rdata | output | DW | Read data, valid one cycle after bus_rd, else zero |
| slot_tick | input | 1 | Time-slot boundary strobe |
| rx_capture | input | 1 | Load receive words from rx_in into active receive buffers |
| rx_in | input | NSER*DW | Receive words from the serializers, lane n at [n*DW +: DW] |
| tx_out | output | NSER*DW | Transmit buffer contents, lane n at [n*DW +: DW] |
| tx_full | output | NSER | Transmit buffer n holds a word for this slot |
| tx_ready | output | 1 | Transmit data ready event |
| rx_ready | output | 1 | Receive data ready event |
| underrun | output | 1 | Sticky transmit underrun |
| overrun | output | 1 | Sticky receive overrun |

## Verification
The assertions assume that slot_tick and rx_capture never coincide with a buffer access. The block drops such an access, and the properties that count tx_full bits rely on this separation. The stimulus issues every bus access, tick and capture as a separate pulse with idle cycles in between, so no two of them share a cycle. Status clears are written only when no flag-setting event occurs in the same cycle.

// File: rtl/sbuf_router.sv
module sbuf_router #(
  parameter int NSER     = 16,
  parameter int DW       = 32,
  parameter int AW       = 6,
  parameter int CFG_BASE = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  input  logic               slot_tick,
  input  logic               rx_capture,
  input  logic [NSER*DW-1:0] rx_in,
  output logic [NSER*DW-1:0] tx_out,
  output logic [NSER-1:0]    tx_full,
  output logic               tx_ready,
  output logic               rx_ready,
  output logic               underrun,
  output logic               overrun
);
  localparam int MW = 2 * NSER;
  localparam int IW = (NSER > 1) ? $clog2(NSER) : 1;

  logic [MW-1:0]   mode_pend, mode_act;
  logic [1:0]      sel_pend, sel_act;
  logic [NSER-1:0] act_tx, act_rx, pend_rx, nx_rx, rx_full;
  logic [DW-1:0]   txbuf [NSER];
  logic [DW-1:0]   rxbuf [NSER];
  logic [3:0]      sticky;

  for (genvar i = 0; i < NSER; i++) begin : g_lane
    assign act_tx[i]  = mode_act[2*i +: 2] == 2'b01;
    assign act_rx[i]  = mode_act[2*i +: 2] == 2'b10;
    assign pend_rx[i] = mode_pend[2*i +: 2] == 2'b10;
    assign tx_out[i*DW +: DW] = txbuf[i];
  end

  assign nx_rx    = slot_tick ? pend_rx : act_rx;
  assign underrun = sticky[0];
  assign overrun  = sticky[1];

  logic [IW-1:0] tx_ptr, rx_ptr;
  logic          tx_hit, rx_hit;
  always_comb begin
    tx_ptr = '0; tx_hit = 1'b0;
    rx_ptr = '0; rx_hit = 1'b0;
    for (int i = NSER - 1; i >= 0; i--) begin
      if (act_tx[i] && !tx_full[i]) begin tx_ptr = IW'(i); tx_hit = 1'b1; end
      if (rx_full[i])               begin rx_ptr = IW'(i); rx_hit = 1'b1; end
    end
  end

  logic [AW:0]   cfg_off;
  logic [IW-1:0] cfg_idx;
  logic          in_cfg, is_dp, buf_ok;
  assign cfg_off = {1'b0, bus_addr} - (AW+1)'(CFG_BASE);
  assign cfg_idx = cfg_off[IW-1:0];
  assign in_cfg  = (bus_addr >= AW'(CFG_BASE)) && (cfg_off < (AW+1)'(NSER));
  assign is_dp   = bus_addr == '0;
  assign buf_ok  = !slot_tick && !rx_capture;

  logic dp_wr, dp_rd, cfg_wr, cfg_rd, do_tx, do_rx;
  logic [IW-1:0] wr_idx, rd_idx;
  assign dp_wr  = bus_wr && is_dp && !sel_act[0] && buf_ok;
  assign dp_rd  = bus_rd && is_dp && !sel_act[1] && buf_ok;
  assign cfg_wr = bus_wr && in_cfg && sel_act[0] && act_tx[cfg_idx] && buf_ok;
  assign cfg_rd = bus_rd && in_cfg && sel_act[1] && act_rx[cfg_idx] && buf_ok;
  assign wr_idx = dp_wr ? tx_ptr : cfg_idx;
  assign rd_idx = dp_rd ? rx_ptr : cfg_idx;
  assign do_tx  = (dp_wr && tx_hit) || cfg_wr;
  assign do_rx  = (dp_rd && rx_hit) || cfg_rd;

  logic [DW-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    case (bus_addr)
      AW'(1):  rd_val = DW'(sel_pend);
      AW'(2):  rd_val = DW'(mode_pend);
      AW'(3):  rd_val = DW'(sticky);
      default: if (do_rx) rd_val = rxbuf[rd_idx];
    endcase
  end

  logic [3:0] st_set, st_clr;
  assign st_set = {dp_rd && !rx_hit, dp_wr && !tx_hit,
                   slot_tick && |(act_rx & rx_full),
                   slot_tick && |(act_tx & ~tx_full)};
  assign st_clr = (bus_wr && bus_addr == AW'(3)) ? bus_wdata[3:0] : 4'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_pend <= '0; mode_act <= '0;
      sel_pend  <= '0; sel_act  <= '0;
      tx_full   <= '0; rx_full  <= '0;
      sticky    <= '0; bus_rdata <= '0;
      tx_ready  <= 1'b0; rx_ready <= 1'b0;
      for (int i = 0; i < NSER; i++) begin
        txbuf[i] <= '0;
        rxbuf[i] <= '0;
      end
    end else begin
      bus_rdata <= bus_rd ? rd_val : '0;
      tx_ready  <= slot_tick;
      rx_ready  <= rx_capture && |nx_rx;
      sticky    <= (sticky & ~st_clr) | st_set;
      if (bus_wr && bus_addr == AW'(1)) sel_pend  <= bus_wdata[1:0];
      if (bus_wr && bus_addr == AW'(2)) mode_pend <= MW'(bus_wdata);
      if (slot_tick) begin
        mode_act <= mode_pend;
        sel_act  <= sel_pend;
        tx_full  <= '0;
      end else if (do_tx) begin
        txbuf[wr_idx]   <= bus_wdata;
        tx_full[wr_idx] <= 1'b1;
      end
      if (rx_capture) begin
        rx_full <= nx_rx;
        for (int i = 0; i < NSER; i++)
          if (nx_rx[i]) rxbuf[i] <= rx_in[i*DW +: DW];
      end else if (slot_tick) begin
        rx_full <= '0;
      end else if (do_rx) begin
        rx_full[rd_idx] <= 1'b0;
      end
    end
  end
endmodule

module sbuf_router_chk #(
  parameter int NSER = 16,
  parameter int DW   = 32,
  parameter int AW   = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            slot_tick,
  input logic            bus_wr,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic [NSER-1:0] tx_full,
  input logic [NSER-1:0] act_tx,
  input logic [NSER-1:0] act_rx,
  input logic [NSER-1:0] rx_full,
  input logic            underrun,
  input logic            overrun,
  input logic            tx_ready
);
  a_r8_underrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    slot_tick && |(act_tx & ~tx_full) |=> underrun);
  a_r9_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    slot_tick && |(act_rx & rx_full) |=> overrun);
  a_r8_tick_empties: assert property (@(posedge clk) disable iff (!rst_n)
    slot_tick |=> tx_full == '0);
  a_r2_full_in_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full & ~act_tx) == '0);
  a_r3_one_fill: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_tick |=> $countones(tx_full) <= $countones($past(tx_full)) + 1);
  a_r11_tx_ready: assert property (@(posedge clk) disable iff (!rst_n)
    slot_tick |=> tx_ready);
  a_r10_sticky_under: assert property (@(posedge clk) disable iff (!rst_n)
    underrun && !(bus_wr && bus_addr == AW'(3) && bus_wdata[0]) |=> underrun);
endmodule

bind sbuf_router sbuf_router_chk #(.NSER(NSER), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .tx_full(tx_full),
  .act_tx(act_tx), .act_rx(act_rx), .rx_full(rx_full),
  .underrun(underrun), .overrun(overrun), .tx_ready(tx_ready));

// File: tb/sbuf_router_test.sv
module sbuf_router_test;
  localparam int NS = 16, DW = 32, AW = 6, CB = 16;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0, slot_tick = 0, rx_capture = 0;
  logic [AW-1:0] bus_addr = 0;
  logic [DW-1:0] bus_wdata = 0, bus_rdata;
  logic [NS*DW-1:0] rx_in = 0, tx_out;
  logic [NS-1:0] tx_full;
  logic tx_ready, rx_ready, underrun, overrun;

  always #5 clk = ~clk;

  sbuf_router #(.NSER(NS), .DW(DW), .AW(AW), .CFG_BASE(CB)) uut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference
  logic [31:0] m_mode_p, m_mode_a;
  logic [1:0]  m_sel_p, m_sel_a;
  bit   [NS-1:0] m_full, m_rxf;
  logic [DW-1:0] m_tx [NS];
  logic [DW-1:0] m_rx [NS];
  logic [3:0]  m_st;
  logic [DW-1:0] e_rdata;
  bit e_txr, e_rxr;

  function automatic bit [NS-1:0] mask_of(logic [31:0] w, logic [1:0] code);
    bit [NS-1:0] m;
    for (int i = 0; i < NS; i++) m[i] = (w[2*i +: 2] == code);
    return m;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode_p = 0; m_mode_a = 0; m_sel_p = 0; m_sel_a = 0;
      m_full = 0; m_rxf = 0; m_st = 0; e_rdata = 0; e_txr = 0; e_rxr = 0;
      for (int i = 0; i < NS; i++) begin m_tx[i] = 0; m_rx[i] = 0; end
    end else begin
      automatic bit [NS-1:0] atx = mask_of(m_mode_a, 2'b01);
      automatic bit [NS-1:0] arx = mask_of(m_mode_a, 2'b10);
      automatic bit quiet = !slot_tick && !rx_capture;
      automatic int a = bus_addr;
      automatic bit cfg = (a >= CB) && (a < CB + NS);
      automatic int ci = a - CB;
      automatic logic [DW-1:0] rv = 0;
      automatic logic [3:0] set = 0, clr = 0;
      automatic int tp = -1, rp = -1;
      for (int i = 0; i < NS; i++) begin
        if (tp < 0 && atx[i] && !m_full[i]) tp = i;
        if (rp < 0 && m_rxf[i]) rp = i;
      end
      if (bus_rd) begin
        if (a == 1) rv = m_sel_p;
        else if (a == 2) rv = m_mode_p;
        else if (a == 3) rv = m_st;
        else if (quiet && a == 0 && !m_sel_a[1]) begin
          if (rp >= 0) begin rv = m_rx[rp]; m_rxf[rp] = 0; end
          else set[3] = 1;
        end else if (quiet && cfg && m_sel_a[1] && arx[ci]) begin
          rv = m_rx[ci]; m_rxf[ci] = 0;
        end
      end
      e_rdata = bus_rd ? rv : 0;
      if (bus_wr) begin
        if (a == 1) m_sel_p = bus_wdata[1:0];
        else if (a == 2) m_mode_p = bus_wdata;
        else if (a == 3) clr = bus_wdata[3:0];
        else if (quiet && a == 0 && !m_sel_a[0]) begin
          if (tp >= 0) begin m_tx[tp] = bus_wdata; m_full[tp] = 1; end
          else set[2] = 1;
        end else if (quiet && cfg && m_sel_a[0] && atx[ci]) begin
          m_tx[ci] = bus_wdata; m_full[ci] = 1;
        end
      end
      if (slot_tick) begin
        set[0] = |(atx & ~m_full);
        set[1] = |(arx & m_rxf);
        m_mode_a = m_mode_p; m_sel_a = m_sel_p;
        m_full = 0; m_rxf = 0;
      end
      e_rxr = 0;
      if (rx_capture) begin
        automatic bit [NS-1:0] nrx = mask_of(m_mode_a, 2'b10);
        m_rxf = nrx;
        e_rxr = |nrx;
        for (int i = 0; i < NS; i++) if (nrx[i]) m_rx[i] = rx_in[i*DW +: DW];
      end
      e_txr = slot_tick;
      m_st = (m_st & ~clr) | set;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk(tx_full == m_full, "R3 model tx_full", DW'(tx_full), DW'(m_full));
    chk(underrun == m_st[0], "R8 model underrun", DW'(underrun), DW'(m_st[0]));
    chk(overrun == m_st[1], "R9 model overrun", DW'(overrun), DW'(m_st[1]));
    chk(tx_ready == e_txr && rx_ready == e_rxr, "R11 model events",
        DW'({tx_ready, rx_ready}), DW'({e_txr, e_rxr}));
    chk(bus_rdata == e_rdata, "R4 model rdata", bus_rdata, e_rdata);
    for (int i = 0; i < NS; i++)
      if (m_full[i]) chk(tx_out[i*DW +: DW] == m_tx[i], "R6 model tx_out",
                         tx_out[i*DW +: DW], m_tx[i]);
  end

  task automatic wr(int a, logic [DW-1:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(int a, output logic [DW-1:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = AW'(a);
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic tick();
    @(negedge clk); slot_tick = 1;
    @(negedge clk); slot_tick = 0;
  endtask

  task automatic capture(logic [DW-1:0] base);
    @(negedge clk);
    for (int i = 0; i < NS; i++) rx_in[i*DW +: DW] = base + DW'(i);
    rx_capture = 1;
    @(negedge clk); rx_capture = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(bus_rdata == 0 && tx_full == 0 && !underrun && !overrun, "R1 reset outputs",
        DW'({bus_rdata[0], tx_full, underrun, overrun}), 0);
    rd(3, d); chk(d == 0, "R1 status after reset", d, 0);
    rd(2, d); chk(d == 0, "R1 mode after reset", d, 0);

    // tx on 0,4,5; rx on 1,2,3
    wr(2, 32'h5A9);
    wr(0, 32'hDEAD);
    chk(tx_full == 0, "R2 mode deferred", DW'(tx_full), 0);
    rd(3, d); chk(d == 4, "R2 write before tick flags excess", d, 4);
    wr(3, 4); rd(3, d); chk(d == 0, "R10 w1c clear", d, 0);

    tick();
    chk(tx_ready == 1, "R11 tx_ready after tick", DW'(tx_ready), 1);
    wr(0, 32'hA0); chk(tx_full == 16'h0001, "R3 first fill to 0", DW'(tx_full), 1);
    wr(0, 32'hA4); chk(tx_full == 16'h0011, "R3 second fill to 4", DW'(tx_full), 32'h11);
    wr(0, 32'hA5); chk(tx_full == 16'h0031, "R3 third fill to 5", DW'(tx_full), 32'h31);
    chk(tx_out[4*DW +: DW] == 32'hA4, "R3 lane 4 data", tx_out[4*DW +: DW], 32'hA4);
    wr(0, 32'hBB);
    chk(tx_full == 16'h0031 && tx_out[5*DW +: DW] == 32'hA5, "R5 excess write ignored",
        tx_out[5*DW +: DW], 32'hA5);
    rd(3, d); chk(d == 4, "R5 excess write status", d, 4);
    wr(3, 4);

    capture(32'h100);
    chk(rx_ready == 1, "R11 rx_ready after capture", DW'(rx_ready), 1);
    rd(0, d); chk(d == 32'h101, "R4 read serializer 1", d, 32'h101);
    rd(0, d); chk(d == 32'h102, "R4 read serializer 2", d, 32'h102);
    rd(0, d); chk(d == 32'h103, "R4 read serializer 3", d, 32'h103);
    rd(0, d); chk(d == 0, "R5 excess read zero", d, 0);
    rd(3, d); chk(d == 8, "R5 excess read status", d, 8);
    wr(3, 8);

    tick();
    chk(!underrun && !overrun, "R8 no flags on full service",
        DW'({underrun, overrun}), 0);
    chk(tx_full == 0, "R8 tick empties", DW'(tx_full), 0);

    wr(0, 32'hC0); wr(0, 32'hC4);
    capture(32'h300);
    rd(0, d); chk(d == 32'h301, "R4 partial read", d, 32'h301);
    tick();
    chk(underrun == 1, "R8 underrun on missed write", DW'(underrun), 1);
    chk(overrun == 1, "R9 overrun on missed read", DW'(overrun), 1);
    wr(3, 1); rd(3, d); chk(d == 2, "R10 only written bit cleared", d, 2);
    wr(3, 2); rd(3, d); chk(d == 0, "R10 overrun cleared", d, 0);

    // direct mode both ways
    wr(1, 3);
    tick();
    wr(3, 1);
    wr(CB + 5, 32'hE5); chk(tx_full == 16'h0020, "R6 direct write 5", DW'(tx_full), 32'h20);
    wr(CB + 1, 32'hE1); chk(tx_full == 16'h0020, "R7 write to rx ignored", DW'(tx_full), 32'h20);
    wr(CB + 7, 32'hE7); chk(tx_full == 16'h0020, "R7 write to idle ignored", DW'(tx_full), 32'h20);
    wr(0, 32'hEE);      chk(tx_full == 16'h0020, "R6 shared port off in direct", DW'(tx_full), 32'h20);
    capture(32'h200);
    rd(CB + 2, d); chk(d == 32'h202, "R7 direct read 2", d, 32'h202);
    rd(CB + 4, d); chk(d == 0, "R7 read of tx serializer zero", d, 0);
    rd(CB + 9, d); chk(d == 0, "R7 read of idle zero", d, 0);
    wr(CB + 0, 32'hE0); wr(CB + 4, 32'hE4);
    rd(CB + 1, d); chk(d == 32'h201, "R7 direct read 1", d, 32'h201);
    rd(CB + 3, d); chk(d == 32'h203, "R7 direct read 3", d, 32'h203);
    tick();
    chk(!underrun && !overrun, "R9 direct slot clean", DW'({underrun, overrun}), 0);
    repeat (3) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule